// File: doc/BRIEF.md
# PWM and Divided-Clock Timer Peripheral

This peripheral sits on a processor bus with a 12-bit address and 16-bit data, and only ever takes writes. It holds two 3-bit settings. One sets the duty cycle of a pulse-width output that has eight steps per period. The other picks which power-of-two divided clock a free-running 8-bit counter drives onto the timer output.

Software changes the pulse width by storing a code to the duty address. It changes the timer frequency by storing a code to the timer address. Only the low three bits of the written word are kept. Neither counter can be stopped or restarted by software, so both outputs run from the moment reset is released.

Top module: `pwm_divtimer_periph`

## Requirements
- R1: While reset is asserted and after it is released, both settings hold code 0 and both counters start at 0. The pulse output is therefore high for only the first of every eight cycles, and the timer output is low in the first cycle.
- R2: A write (`bus_we`=1) to address 0x040 loads `bus_wdata[2:0]` into the duty setting. Bits 15:3 of the data have no effect.
- R3: A write to address 0x080 loads `bus_wdata[2:0]` into the timer select setting. Bits 15:3 of the data have no effect.
- R4: A write to any other address leaves both settings unchanged. So does any cycle with `bus_we`=0, whatever the address and data.
- R5: The pulse period is 8 clock cycles. With an active duty code n from 1 to 7, `pwm_out` is high for the first n cycles of each period and low for the rest.
- R6: Duty code 0 behaves as code 1, which gives a high time of 1/8. The output is never constantly low or constantly high.
- R7: A new duty code takes effect only at a period boundary. At the clock edge that ends a period, the duty setting held at that edge governs the whole next period.
- R8: An 8-bit counter increments on every clock after reset and wraps from 255 to 0. With timer code k from 0 to 6, `tmr_out` equals bit k of that counter. This is a square wave with a period of 2^(k+1) cycles, low in the first half.
- R9: Timer code 7 behaves as code 6, which divides the clock by 128.
- R10: Writing the timer or duty setting never resets or pauses either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Write address |
| bus_wdata | input | 16 | Write data; only bits 2:0 are stored |
| bus_we | input | 1 | Write strobe, one cycle per write |
| pwm_out | output | 1 | Pulse-width output |
| tmr_out | output | 1 | Selected divided-clock output |

## Verification
The bench writes new duty codes at every phase of the pulse period. A design that applied a code at once, instead of at the boundary, would produce truncated or stretched pulses in the period where the write landed. It also stores codes 0 and 7 to both settings, which catches missing clamps: those would show up as a dead pulse output or a timer stuck on a wrong tap. Writes to neighbouring addresses, and strobe-low cycles that carry a matching address, would expose a loose address decode through a change at the outputs. Repeated timer writes would reveal a counter that restarts on a write, because the output phase would break.

// File: rtl/pwm_divtimer_periph.sv
module pwm_divtimer_periph #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int CODE_W = 3,
  parameter int TMR_W = 8,
  parameter logic [ADDR_W-1:0] DUTY_ADDR = 12'h040,
  parameter logic [ADDR_W-1:0] TSEL_ADDR = 12'h080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic              pwm_out,
  output logic              tmr_out
);
  localparam int MAX_TAP = TMR_W - 2;
  localparam logic [CODE_W-1:0] TOP_STEP = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] MIN_DUTY = CODE_W'(1);
  localparam logic [CODE_W-1:0] TAP_LIM = CODE_W'(MAX_TAP);

  logic [CODE_W-1:0] duty_code, duty_live, step;
  logic [CODE_W-1:0] tsel_code, tap;
  logic [TMR_W-1:0]  tcnt;
  logic              duty_hit, tsel_hit, wrap;

  assign duty_hit = bus_we && (bus_addr == DUTY_ADDR);
  assign tsel_hit = bus_we && (bus_addr == TSEL_ADDR);
  assign wrap     = (step == TOP_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_code <= '0;
      tsel_code <= '0;
    end else begin
      if (duty_hit) duty_code <= bus_wdata[CODE_W-1:0];
      if (tsel_hit) tsel_code <= bus_wdata[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= '0;
      duty_live <= MIN_DUTY;
    end else begin
      step <= step + 1'b1;
      if (wrap) duty_live <= (duty_code == '0) ? MIN_DUTY : duty_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt + 1'b1;
  end

  assign pwm_out = (step < duty_live);
  assign tap     = (tsel_code > TAP_LIM) ? TAP_LIM : tsel_code;
  assign tmr_out = tcnt[tap];

  // R5
  period_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0) |-> pwm_out);

  // R6
  period_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> !pwm_out);

  // R7
  duty_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_live));

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_hit |=> $stable(duty_code));

  // R4
  tsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tsel_hit |=> $stable(tsel_code));

  // R10
  tcnt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tcnt == $past(tcnt) + 1'b1));
endmodule

// File: tb/sim_pwm_divtimer_periph.sv
`timescale 1ns/100ps
module sim_pwm_divtimer_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        pwm_out, tmr_out;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  int m_duty, m_live, m_tsel, m_step, m_tcnt;

  always #2.5 clk = ~clk;

  pwm_divtimer_periph u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .pwm_out(pwm_out), .tmr_out(tmr_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_duty = 0; m_tsel = 0; m_step = 0; m_live = 1; m_tcnt = 0;
    end else begin
      if (m_step == 7) m_live = (m_duty == 0) ? 1 : m_duty;
      m_step = (m_step + 1) % 8;
      m_tcnt = (m_tcnt + 1) % 256;
      if (bus_we && bus_addr == 12'h040) m_duty = bus_wdata & 7;
      if (bus_we && bus_addr == 12'h080) m_tsel = bus_wdata & 7;
    end
  end

  task automatic compare();
    logic ep, et;
    int k;
    k  = (m_tsel > 6) ? 6 : m_tsel;
    ep = (m_step < m_live);
    et = ((m_tcnt >> k) & 1) != 0;
    vectors++;
    if (pwm_out !== ep) begin
      miscompares++;
      $display("FAIL %s pwm_out actual=%b expected=%b", tag, pwm_out, ep);
    end
    if (tmr_out !== et) begin
      miscompares++;
      $display("FAIL %s tmr_out actual=%b expected=%b", tag, tmr_out, et);
    end
  endtask

  task automatic tick(input logic we, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    compare();
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 12'h000, 16'h0000);
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    tick(1'b1, a, d);
  endtask

  initial begin
    fork
      begin
        // R1 reset state and first periods
        tag = "R1";
        @(posedge clk); @(posedge clk);
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(20);
        // R6 code 0 clamps to one eighth
        tag = "R6";
        wr(12'h040, 16'h0000); idle(24);
        // R2 upper data bits ignored
        tag = "R2";
        wr(12'h040, 16'hFFF5); idle(32);
        // R5 each duty code
        tag = "R5";
        for (int n = 1; n < 8; n++) begin
          wr(12'h040, 16'(n)); idle(16);
        end
        // R7 writes at every period phase
        tag = "R7";
        for (int p = 0; p < 8; p++) begin
          idle(p);
          wr(12'h040, 16'((p * 3) % 8));
          idle(11);
        end
        // R3 timer select, upper bits ignored
        tag = "R3";
        wr(12'h080, 16'hABC3); idle(40);
        // R8 every tap
        tag = "R8";
        for (int k = 0; k < 7; k++) begin
          wr(12'h080, 16'(k)); idle(300);
        end
        // R9 code 7 clamps to divide by 128
        tag = "R9";
        wr(12'h080, 16'h0007); idle(300);
        // R10 repeated writes do not restart counters
        tag = "R10";
        for (int i = 0; i < 20; i++) begin
          wr(12'h080, 16'h0002); wr(12'h040, 16'h0003); idle(5);
        end
        // R4 other addresses and strobe-low cycles
        tag = "R4";
        wr(12'h080, 16'h0001); wr(12'h040, 16'h0006); idle(16);
        wr(12'h041, 16'h0002); wr(12'h081, 16'h0005);
        wr(12'h000, 16'h0001); wr(12'hFFF, 16'h0004);
        wr(12'h0C0, 16'h0007); idle(20);
        tick(1'b0, 12'h040, 16'h0001); tick(1'b0, 12'h080, 16'h0006);
        idle(40);
      end
      begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired in %s", tag);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule